// File: doc/BRIEF.md
# Slot-Queued SPI Master

This block is an SPI master that works through a queue of transfer slots without help from a processor. Each slot has a transmit entry, a receive entry and a command byte. The command byte picks the peripheral, sets the slot's word length, and says whether chip select stays asserted into the following slot.

Software sets the serial clock divisor and the SPI mode, fills the slots, and writes the first and last slot indices. It then sets a start bit. The sequencer walks the slots from the first index to the last one, both included, and wraps past the top slot. It writes each received word back into its slot. When the final slot is done it raises a sticky done flag, clears the start bit, and drives the interrupt line if interrupts are enabled.

All registers sit on a byte-wide write bus with a combinational read port.

Top module: `spi_slot_queue`

## Requirements
- R1: After reset the chip selects are all high, the serial clock is low, the interrupt is low, and both the status register (0x05) and the run register (0x04) read 0.
- R2: A started queue processes slots from the first index (0x02) to the last index (0x03), both included, stepping by one and wrapping from the top slot to slot 0. Every bit the master drives is part of one of these slots.
- R3: Command bit 7 set keeps chip select asserted from one slot into the next, so there is no high gap. Command bit 7 clear releases chip select after the slot. Chip select is always released after the final slot.
- R4: Command bit 6 set makes a wide slot. Its length comes from control bits 5:2, where 0 means 16 bits. Command bit 6 clear makes an 8-bit slot.
- R5: While a slot runs, chip-select output i equals bit i of the command byte, active low.
- R6: Between two serial clock edges within a slot there are exactly as many module clock cycles as the divisor register (0x00) holds.
- R7: Control bit 1 sets the clock idle level (CPOL). With control bit 0 (CPHA) clear, data is sampled on the first edge of each bit period; with it set, on the second edge. Words are sent and received most significant bit first.
- R8: Slot s transmit data sits at 0x20+2s (high byte) and 0x21+2s (low byte), receive data at 0x40+2s and 0x41+2s, and the command at 0x60+s. An 8-bit slot uses only the low byte and leaves the receive high byte unchanged. A wide slot of w bits sends the low w bits of {high,low} and stores the received word zero-extended.
- R9: Writing run register bit 6 starts the queue. The queue only starts while control bit 7 (master enable) is set. Bit 6 clears itself when the queue completes. Bit 7 of the run register is stored and reads back.
- R10: Status bit 0 is set after the final slot and stays set until a 0 is written to it. The interrupt is high exactly while this bit and run register bit 5 are both set.
- R11: While the queue runs, every register write except to the status register is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| irq | output | 1 | Queue-complete interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | CS_W | Active-low chip selects |

## Verification
The assertions assume that every command byte the queue reaches selects at least one peripheral. The check that chip select is asserted during shifting depends on this. They also assume that the clock polarity only changes while the queue is idle. The stimulus always writes a single-zero chip-select mask into each slot it uses. It sets the mode only between runs, and its one write to the control register during a run is meant to be rejected. The serial data input is driven as the inverse of the serial data output, so every received word has a value the bench can predict from the transmit entry.

// File: rtl/spi_q_pkg.sv
package spi_q_pkg;
   localparam logic [7:0] ADR_DIV    = 8'h00;
   localparam logic [7:0] ADR_CTRL   = 8'h01;
   localparam logic [7:0] ADR_QFIRST = 8'h02;
   localparam logic [7:0] ADR_QLAST  = 8'h03;
   localparam logic [7:0] ADR_RUN    = 8'h04;
   localparam logic [7:0] ADR_STAT   = 8'h05;
   localparam logic [2:0] PAGE_TX    = 3'b001;
   localparam logic [2:0] PAGE_RX    = 3'b010;
   localparam logic [2:0] PAGE_CMD   = 3'b011;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_SETUP,
      SQ_SHIFT,
      SQ_GAP,
      SQ_END
   } sq_state_t;

   function automatic logic [4:0] slot_bits(input logic wide, input logic [3:0] bpw);
      if (!wide)
         return 5'd8;
      return (bpw == 4'd0) ? 5'd16 : {1'b0, bpw};
   endfunction
endpackage

// File: rtl/spi_q_tick.sv
module spi_q_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] eff;

   assign eff  = (div == '0) ? DIV_W'(1) : div;
   assign tick = run && (cnt == eff - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + DIV_W'(1);
   end
endmodule

// File: rtl/spi_q_engine.sv
module spi_q_engine #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [4:0]        width,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              tick,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] rx_word
);
   localparam int EC_W = $clog2(2 * WORD_W) + 1;

   logic [WORD_W-1:0] sh_tx;
   logic [WORD_W-1:0] sh_rx;
   logic [EC_W-1:0]   edge_cnt;
   logic [EC_W-1:0]   edge_last;
   logic [4:0]        width_q;
   logic              sample_now;

   assign edge_last  = EC_W'({width_q, 1'b0}) - EC_W'(1);
   assign sample_now = (~edge_cnt[0]) ^ cpha;
   assign mosi       = sh_tx[WORD_W-1];
   assign rx_word    = sh_rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         sclk     <= 1'b0;
         sh_tx    <= '0;
         sh_rx    <= '0;
         edge_cnt <= '0;
         width_q  <= 5'd8;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy     <= 1'b1;
            edge_cnt <= '0;
            width_q  <= width;
            sh_tx    <= tx_word << (5'(WORD_W) - width);
            sh_rx    <= '0;
         end else if (busy) begin
            if (tick) begin
               sclk     <= ~sclk;
               edge_cnt <= edge_cnt + EC_W'(1);
               if (sample_now)
                  sh_rx <= {sh_rx[WORD_W-2:0], miso};
               else if (edge_cnt != '0)
                  sh_tx <= {sh_tx[WORD_W-2:0], 1'b0};
               if (edge_cnt == edge_last) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end
         end else begin
            sclk <= cpol;
         end
      end
   end
endmodule

// File: rtl/spi_q_seq.sv
module spi_q_seq
   import spi_q_pkg::*;
#(
   parameter int SLOTS = 16,
   parameter int CS_W  = 4,
   localparam int PTR_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [PTR_W-1:0] first_ptr,
   input  logic [PTR_W-1:0] last_ptr,
   input  logic [3:0]       bpw,
   input  logic [7:0]       cmd_byte,
   input  logic             tick,
   input  logic             eng_done,
   output logic [PTR_W-1:0] cmd_idx,
   output logic [PTR_W-1:0] cur_idx,
   output logic             busy,
   output logic [CS_W-1:0]  cs_n,
   output logic             eng_start,
   output logic [4:0]       eng_width,
   output logic             rx_we,
   output logic             rx_wide,
   output logic             finish
);
   sq_state_t        state;
   logic [PTR_W-1:0] cur;
   logic [PTR_W-1:0] last_q;
   logic             wide_q;
   logic             cont_q;
   logic [PTR_W-1:0] nxt;
   logic             unused_cmd;

   assign unused_cmd = ^cmd_byte[5:CS_W];
   assign nxt        = cur + PTR_W'(1);
   assign busy       = (state != SQ_IDLE);
   assign cur_idx    = cur;
   assign eng_start  = (state == SQ_SETUP) && tick;
   assign eng_width  = slot_bits(cmd_byte[6], bpw);
   assign rx_we      = (state == SQ_SHIFT) && eng_done;
   assign rx_wide    = wide_q;
   assign finish     = (state == SQ_END) && tick;

   always_comb begin
      unique case (state)
         SQ_IDLE:           cmd_idx = first_ptr;
         SQ_SHIFT, SQ_GAP:  cmd_idx = nxt;
         default:           cmd_idx = cur;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         cur    <= '0;
         last_q <= '0;
         wide_q <= 1'b0;
         cont_q <= 1'b0;
         cs_n   <= '1;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               cs_n <= '1;
               if (go) begin
                  cur    <= first_ptr;
                  last_q <= last_ptr;
                  cs_n   <= cmd_byte[CS_W-1:0];
                  state  <= SQ_SETUP;
               end
            end
            SQ_SETUP: begin
               if (tick) begin
                  wide_q <= cmd_byte[6];
                  cont_q <= cmd_byte[7];
                  state  <= SQ_SHIFT;
               end
            end
            SQ_SHIFT: begin
               if (eng_done) begin
                  if (cur == last_q) begin
                     cs_n  <= '1;
                     state <= SQ_END;
                  end else if (cont_q) begin
                     cur   <= nxt;
                     cs_n  <= cmd_byte[CS_W-1:0];
                     state <= SQ_SETUP;
                  end else begin
                     cs_n  <= '1;
                     state <= SQ_GAP;
                  end
               end
            end
            SQ_GAP: begin
               if (tick) begin
                  cur   <= nxt;
                  cs_n  <= cmd_byte[CS_W-1:0];
                  state <= SQ_SETUP;
               end
            end
            default: begin
               if (tick)
                  state <= SQ_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/spi_q_regs.sv
module spi_q_regs
   import spi_q_pkg::*;
#(
   parameter int SLOTS = 16,
   parameter int WORD_W = 16,
   localparam int PTR_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [7:0]        addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              busy,
   input  logic              finish,
   input  logic              rx_we,
   input  logic [PTR_W-1:0]  rx_idx,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              rx_wide,
   input  logic [PTR_W-1:0]  tx_idx,
   output logic [WORD_W-1:0] tx_word,
   input  logic [PTR_W-1:0]  cmd_idx,
   output logic [7:0]        cmd_byte,
   output logic [7:0]        div,
   output logic              cpol,
   output logic              cpha,
   output logic [3:0]        bpw,
   output logic              go,
   output logic [PTR_W-1:0]  first_ptr,
   output logic [PTR_W-1:0]  last_ptr,
   output logic              run_en,
   output logic              irq
);
   logic [7:0] tx_hi [SLOTS];
   logic [7:0] tx_lo [SLOTS];
   logic [7:0] rx_hi [SLOTS];
   logic [7:0] rx_lo [SLOTS];
   logic [7:0] cmd   [SLOTS];
   logic [7:0] ctrl;
   logic       run_hold;
   logic       run_ie;
   logic       done;
   logic       acc;
   logic [3:0] a_slot;
   logic [4:0] a_cmd;

   assign acc    = we && (!busy || addr == ADR_STAT);
   assign a_slot = addr[4:1];
   assign a_cmd  = addr[4:0];

   assign cpol     = ctrl[1];
   assign cpha     = ctrl[0];
   assign bpw      = ctrl[5:2];
   assign go       = run_en && ctrl[7];
   assign irq      = done && run_ie;
   assign tx_word  = {tx_hi[tx_idx], tx_lo[tx_idx]};
   assign cmd_byte = cmd[cmd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div       <= 8'd8;
         ctrl      <= 8'h00;
         first_ptr <= '0;
         last_ptr  <= '0;
         run_hold  <= 1'b0;
         run_en    <= 1'b0;
         run_ie    <= 1'b0;
         done      <= 1'b0;
      end else begin
         if (finish) begin
            run_en <= 1'b0;
            done   <= 1'b1;
         end
         if (acc) begin
            unique case (addr)
               ADR_DIV:    div       <= wdata;
               ADR_CTRL:   ctrl      <= wdata;
               ADR_QFIRST: first_ptr <= wdata[PTR_W-1:0];
               ADR_QLAST:  last_ptr  <= wdata[PTR_W-1:0];
               ADR_RUN: begin
                  run_hold <= wdata[7];
                  run_en   <= wdata[6];
                  run_ie   <= wdata[5];
               end
               ADR_STAT:   if (!wdata[0] && !finish) done <= 1'b0;
               default: ;
            endcase
         end
      end
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tx_hi[s] <= '0;
            tx_lo[s] <= '0;
            cmd[s]   <= '0;
         end else if (acc) begin
            if (addr[7:5] == PAGE_TX && a_slot == 4'(s)) begin
               if (addr[0]) tx_lo[s] <= wdata;
               else         tx_hi[s] <= wdata;
            end
            if (addr[7:5] == PAGE_CMD && a_cmd == 5'(s))
               cmd[s] <= wdata;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rx_hi[s] <= '0;
            rx_lo[s] <= '0;
         end else if (rx_we && rx_idx == PTR_W'(s)) begin
            rx_lo[s] <= rx_word[7:0];
            if (rx_wide)
               rx_hi[s] <= rx_word[WORD_W-1:8];
         end
      end
   end

   always_comb begin
      rdata = 8'h00;
      unique case (addr[7:5])
         3'b000: begin
            unique case (addr)
               ADR_DIV:    rdata = div;
               ADR_CTRL:   rdata = ctrl;
               ADR_QFIRST: rdata = 8'(first_ptr);
               ADR_QLAST:  rdata = 8'(last_ptr);
               ADR_RUN:    rdata = {run_hold, run_en, run_ie, 5'b0};
               ADR_STAT:   rdata = {7'b0, done};
               default:    rdata = 8'h00;
            endcase
         end
         PAGE_TX:  if (32'(a_slot) < SLOTS) rdata = addr[0] ? tx_lo[a_slot[PTR_W-1:0]] : tx_hi[a_slot[PTR_W-1:0]];
         PAGE_RX:  if (32'(a_slot) < SLOTS) rdata = addr[0] ? rx_lo[a_slot[PTR_W-1:0]] : rx_hi[a_slot[PTR_W-1:0]];
         PAGE_CMD: if (32'(a_cmd) < SLOTS) rdata = cmd[a_cmd[PTR_W-1:0]];
         default:  rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/spi_slot_queue.sv
module spi_slot_queue #(
   parameter int SLOTS = 16,
   parameter int CS_W  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic [7:0]      reg_addr,
   input  logic [7:0]      reg_wdata,
   output logic [7:0]      reg_rdata,
   output logic            irq,
   output logic            sclk,
   output logic            mosi,
   input  logic            miso,
   output logic [CS_W-1:0] cs_n
);
   localparam int PTR_W  = $clog2(SLOTS);
   localparam int WORD_W = 16;
   localparam int DIV_W  = 8;

   if (SLOTS < 2 || SLOTS > 16 || (1 << PTR_W) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two from 2 to 16");
   end
   if (CS_W < 1 || CS_W > 4) begin : g_bad_cs
      $error("CS_W must be 1 to 4");
   end

   logic [PTR_W-1:0]  cmd_idx, cur_idx, first_ptr, last_ptr;
   logic [7:0]        cmd_byte, div;
   logic [WORD_W-1:0] tx_word, rx_word;
   logic [3:0]        bpw;
   logic [4:0]        eng_width;
   logic              cpol, cpha, go, run_en, seq_busy, tick;
   logic              eng_start, eng_done, eng_busy, rx_we, rx_wide, finish;

   spi_q_regs #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_regs (
      .clk, .rst_n,
      .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
      .busy(seq_busy), .finish,
      .rx_we, .rx_idx(cur_idx), .rx_word, .rx_wide,
      .tx_idx(cur_idx), .tx_word,
      .cmd_idx, .cmd_byte,
      .div, .cpol, .cpha, .bpw, .go, .first_ptr, .last_ptr, .run_en, .irq
   );

   spi_q_tick #(.DIV_W(DIV_W)) u_tick (
      .clk, .rst_n, .run(seq_busy), .div, .tick
   );

   spi_q_seq #(.SLOTS(SLOTS), .CS_W(CS_W)) u_seq (
      .clk, .rst_n, .go, .first_ptr, .last_ptr, .bpw, .cmd_byte, .tick,
      .eng_done, .cmd_idx, .cur_idx, .busy(seq_busy), .cs_n, .eng_start,
      .eng_width, .rx_we, .rx_wide, .finish
   );

   spi_q_engine #(.WORD_W(WORD_W)) u_eng (
      .clk, .rst_n, .start(eng_start), .width(eng_width), .tx_word, .tick,
      .cpol, .cpha, .miso, .sclk, .mosi, .busy(eng_busy), .done(eng_done),
      .rx_word
   );
endmodule

// File: rtl/spi_slot_queue_chk.sv
module spi_slot_queue_chk #(
   parameter int CS_W  = 4,
   parameter int PTR_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             eng_busy,
   input logic             tick,
   input logic             sclk,
   input logic             cpol,
   input logic [CS_W-1:0]  cs_n,
   input logic             irq,
   input logic             run_en,
   input logic             reg_we,
   input logic [7:0]       reg_addr,
   input logic [7:0]       reg_rdata,
   input logic [PTR_W-1:0] last_ptr
);
   logic unused_rd;
   assign unused_rd = ^reg_rdata;

   assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy) && $stable(cpol)) |-> ((&cs_n) && sclk == cpol));

   assert_cs_during_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> !(&cs_n));

   assert_edge_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((sclk != $past(sclk)) && $past(eng_busy)) |-> $past(tick));

   assert_enable_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy)) |-> !run_en);

   assert_irq_after_queue_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(busy) || $past(reg_we)));

   assert_busy_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we && reg_addr == 8'h03) |=> $stable(last_ptr));
endmodule

bind spi_slot_queue spi_slot_queue_chk #(.CS_W(CS_W), .PTR_W(PTR_W)) u_chk (
   .clk, .rst_n, .busy(seq_busy), .eng_busy, .tick, .sclk, .cpol, .cs_n,
   .irq, .run_en, .reg_we, .reg_addr, .reg_rdata, .last_ptr
);

// File: tb/spi_slot_queue_test.sv
module spi_slot_queue_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq, sclk, mosi, miso;
   logic [3:0] cs_n;

   assign miso = ~mosi;

   spi_slot_queue #(.SLOTS(16), .CS_W(4)) uut (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .irq, .sclk, .mosi, .miso, .cs_n
   );

   always #2 clk = ~clk;

   int n_chk = 0, n_bad = 0, cyc = 0;
   logic [7:0] m_txh [16], m_txl [16], m_cmd [16], m_rxh [16], m_rxl [16];
   bit   cap [0:1023];
   int   ncap = 0, nsel = 0, min_gap = 1000, gap = 0;
   logic [3:0] last_pat = 4'hF;
   logic b_cpol = 1'b0, b_cpha = 1'b0, cs_hi_prev = 1'b1, sclk_prev = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   always @(sclk)
      if (rst_n && !(&cs_n) && (sclk == ~(b_cpol ^ b_cpha)) && ncap < 1024) begin
         cap[ncap] = mosi;
         ncap++;
      end

   always @(negedge clk) begin
      cyc++;
      if (cs_hi_prev && !(&cs_n)) begin nsel++; last_pat = cs_n; end
      cs_hi_prev = &cs_n;
      if (sclk !== sclk_prev) begin
         if (gap < min_gap) min_gap = gap;
         gap = 1;
      end else gap++;
      sclk_prev = sclk;
      if (cyc > 150000) begin
         n_bad++; n_chk++;
         $display("FAIL R2 watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put_slot(input int s, input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] c);
      wr(8'(8'h20 + 2*s), hi); wr(8'(8'h21 + 2*s), lo); wr(8'(8'h60 + s), c);
      m_txh[s] = hi; m_txl[s] = lo; m_cmd[s] = c;
   endtask

   task automatic run_q(input int st, input int en, input bit ie, input int dv,
                        input logic [3:0] bpw, input int mode, input bit poke);
      logic [7:0] d;
      int n, nbits, mism, bad, nsel_exp, w, p, waitc;
      logic [15:0] data, rx;
      logic [3:0] pat_exp;
      b_cpol = mode[1]; b_cpha = mode[0];
      wr(8'h01, {2'b10, bpw, mode[1:0]});
      wr(8'h00, 8'(dv)); wr(8'h02, 8'(st)); wr(8'h03, 8'(en));
      repeat (4) @(negedge clk);
      ncap = 0; nsel = 0; min_gap = 1000;
      wr(8'h04, {2'b01, ie, 5'b0});
      if (poke) begin
         repeat (40) @(negedge clk);
         wr(8'h03, 8'(st)); wr(8'(8'h21 + 2*en), 8'hA5); wr(8'h01, 8'h00);
      end
      waitc = 0; d = 0;
      while (d[0] !== 1'b1 && waitc < 4000) begin
         repeat (20) @(negedge clk);
         rd(8'h05, d); waitc++;
      end
      n = ((en - st) & 15) + 1;
      nbits = 0; mism = 0; nsel_exp = 0; pat_exp = 4'hF;
      for (int k = 0; k < n; k++) begin
         p = (st + k) & 15;
         if (k == 0 || !m_cmd[(p + 15) & 15][7]) begin nsel_exp++; pat_exp = m_cmd[p][3:0]; end
         w = m_cmd[p][6] ? ((bpw == 0) ? 16 : int'(bpw)) : 8;
         data = m_cmd[p][6] ? {m_txh[p], m_txl[p]} : {8'h00, m_txl[p]};
         for (int b = w - 1; b >= 0; b--) begin
            if (nbits < 1024 && cap[nbits] !== data[b]) mism++;
            nbits++;
         end
         rx = ~data & 16'((32'd1 << w) - 1);
         m_rxl[p] = rx[7:0];
         if (m_cmd[p][6]) m_rxh[p] = rx[15:8];
      end
      chk(d[0] === 1'b1, "R10 done flag", d, 1);
      chk(ncap == nbits, "R2 bit count", ncap, nbits);
      chk(mism == 0, "R7/R4 mosi bit order", mism, 0);
      chk(nsel == nsel_exp, "R3 select windows", nsel, nsel_exp);
      chk(last_pat == pat_exp, "R5 chip-select pattern", last_pat, pat_exp);
      chk(min_gap == dv, "R6 half period", min_gap, dv);
      chk(irq == ie, "R10 irq with done", irq, ie);
      rd(8'h04, d);
      chk(d[6] == 1'b0, "R9 enable self-clear", d, {2'b00, ie, 5'b0});
      bad = 0;
      for (int s = 0; s < 16; s++) begin
         rd(8'(8'h40 + 2*s), d); if (d !== m_rxh[s]) bad++;
         rd(8'(8'h41 + 2*s), d); if (d !== m_rxl[s]) bad++;
      end
      chk(bad == 0, "R8 receive entries", bad, 0);
      wr(8'h05, 8'h00);
      rd(8'h05, d);
      chk(d == 8'h00 && irq == 1'b0, "R10 status clear", {d, 7'b0, irq}, 0);
   endtask

   initial begin
      logic [7:0] d;
      for (int s = 0; s < 16; s++) begin
         m_txh[s] = 0; m_txl[s] = 0; m_cmd[s] = 0; m_rxh[s] = 0; m_rxl[s] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(cs_n == 4'hF && sclk == 1'b0 && irq == 1'b0, "R1 pins", {cs_n, sclk, irq}, 8'h3C);
      rd(8'h05, d); chk(d == 8'h00, "R1 status", d, 0);
      rd(8'h04, d); chk(d == 8'h00, "R1 run", d, 0);

      // R7 and R4: every mode, mixed 8/16-bit slots held in one window
      for (int m = 0; m < 4; m++) begin
         put_slot(0, 8'h00, 8'(8'h3C + 17*m), 8'h8E);
         put_slot(1, 8'(8'hC3 ^ m), 8'(8'h5A + m), 8'hCE);
         put_slot(2, 8'h00, 8'(8'h81 + 3*m), 8'h0E);
         run_q(0, 2, 1'b1, 8, 4'd0, m, 1'b0);
      end

      // R3 and R6: continue clear on every slot, other divisor and device
      put_slot(3, 8'h12, 8'h34, 8'h47);
      put_slot(4, 8'h00, 8'hF0, 8'h07);
      put_slot(5, 8'h9A, 8'h0F, 8'h47);
      run_q(3, 5, 1'b1, 11, 4'd0, 1, 1'b0);

      // R2 and R4: wrap from slot 14 to slot 1, 12-bit wide slots, irq masked
      put_slot(14, 8'hAB, 8'hCD, 8'hCB);
      put_slot(15, 8'h6E, 8'h21, 8'h4B);
      put_slot(0,  8'h00, 8'h99, 8'h8B);
      put_slot(1,  8'hF7, 8'h08, 8'h4B);
      run_q(14, 1, 1'b0, 9, 4'd12, 3, 1'b0);

      // R9: no start without master enable, hold bit stored
      wr(8'h01, 8'h00);
      ncap = 0; nsel = 0;
      wr(8'h04, 8'h40);
      repeat (200) @(negedge clk);
      chk(nsel == 0 && cs_n == 4'hF, "R9 master enable gate", nsel, 0);
      wr(8'h04, 8'h80);
      rd(8'h04, d); chk(d == 8'h80, "R9 hold bit stored", d, 8'h80);

      // R11: full 16-slot queue with writes attempted while busy
      for (int s = 0; s < 16; s++)
         put_slot(s, 8'(s * 37 + 5), 8'(s * 91 + 3), 8'((s % 3 == 0 ? 8'h00 : 8'h80) | (s[0] ? 8'h4D : 8'h0D)));
      run_q(0, 15, 1'b1, 8, 4'd0, 2, 1'b1);
      rd(8'h03, d); chk(d == 8'd15, "R11 last pointer kept", d, 15);
      rd(8'h3F, d); chk(d == m_txl[15], "R11 tx entry kept", d, m_txl[15]);
      rd(8'h01, d); chk(d == 8'h82, "R11 control kept", d, 8'h82);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule